// File: doc/BRIEF.md
# I2C High-Speed Mode Tracker

This block watches an I2C bus from the side and decides, at all times, whether the bus is running in standard/fast mode or in high-speed mode. It samples SCL and SDA on a system clock at least eight times the bus bit rate and passes both lines through a synchronizer. It finds START, repeated START and STOP conditions and assembles the bits that follow a START into bytes.

A bus transfer always begins in standard/fast mode. If the first byte after a START is one of the eight reserved high-speed controller codes, the tracker raises its high-speed output and reports which code arrived. The ninth bit after a controller code should not be acknowledged, and any device that pulls SDA low there raises an error pulse. The high-speed output stays up through repeated STARTs, and the first byte after each repeated START is reported as a target address with its read/write bit. A STOP drops the bus back to standard/fast mode. A first byte that is not a controller code is reported as an ordinary address.

Top module: `i2c_hs_tracker`

## Requirements
- R1: While reset is high, and after it, hs_mode, code_det, addr_valid, nack_err, start_det and stop_det are 0, and code_idx, addr and addr_rw are 0. A reset during high-speed mode drops hs_mode.
- R2: SDA falling while SCL stays high gives a one-cycle start_det pulse 3 clock edges after the SDA change.
- R3: SDA rising while SCL stays high gives a one-cycle stop_det pulse. SDA changes while SCL is high are never shifted in as data bits.
- R4: In standard/fast mode, a first byte after START in the range 0x08 to 0x0F (bits 7:3 equal 00001, all eight bits compared) gives a one-cycle code_det pulse and raises hs_mode, both 4 clock edges after the SCL rise of the eighth bit. code_idx becomes bits 2:0 of that byte.
- R5: Bytes are taken MSB first, one bit per SCL rise. In standard/fast mode, a first byte outside 0x08 to 0x0F (for example 0x07 or 0x10) leaves hs_mode low and is reported with an addr_valid pulse, addr = byte bits 7:1 and addr_rw = byte bit 0.
- R6: A repeated START while hs_mode is high keeps hs_mode high. The first byte after it gives addr_valid with addr = bits 7:1 and addr_rw = bit 0.
- R7: A STOP clears hs_mode one cycle after stop_det.
- R8: The ninth bit after a controller code is sampled. If SDA is low there, nack_err pulses for one cycle. If SDA is high, nack_err stays low.
- R9: Bytes after the address byte never give code_det or addr_valid, even when their value lies in 0x08 to 0x0F.
- R10: addr and addr_rw hold their value until the next START and are cleared to 0 by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| code_det | output | 1 | One-cycle pulse: controller code received |
| code_idx | output | 3 | Index of the last controller code received |
| start_det | output | 1 | One-cycle pulse: START or repeated START |
| stop_det | output | 1 | One-cycle pulse: STOP |
| addr_valid | output | 1 | One-cycle pulse: address byte received |
| addr | output | 7 | Captured target address |
| addr_rw | output | 1 | Captured read/write bit |
| nack_err | output | 1 | One-cycle pulse: controller code was acknowledged |

## Verification
START and STOP pulses come 3 clock edges after the SDA change. Two synchronizer flops and the registered detector account for those edges. code_det, addr_valid, hs_mode and nack_err follow the relevant SCL rise by 4 edges, because the byte assembler adds one more register. The bench records the cycle number at each line change and each pulse and compares the difference against 3 and 4 exactly. All other checks are made half a bus bit or more after the last SCL edge, so every result is already settled when it is read.

// File: rtl/hs_trk_pkg.sv
package hs_trk_pkg;

    localparam int BYTE_W     = 8;
    localparam int CODE_IDX_W = 3;
    localparam int ADDR_W     = BYTE_W - 1;
    localparam logic [BYTE_W-CODE_IDX_W-1:0] HS_CODE_PREFIX = 5'b00001;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FIRST,
        PH_CODE_ACK,
        PH_WAIT_RS,
        PH_PAYLOAD
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } bus_t;

    typedef struct packed {
        logic              done;
        logic [BYTE_W-1:0] data;
        logic              ack_done;
        logic              ack_bit;
    } rx_evt_t;

    function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:CODE_IDX_W] == HS_CODE_PREFIX;
    endfunction

endpackage

// File: rtl/hs_line_sync.sv
module hs_line_sync
    import hs_trk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  bus_t raw,
    output bus_t now_s,
    output bus_t prev_s
);
    localparam int LAST = SYNC_STAGES - 1;

    bus_t chain [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '{scl: 1'b1, sda: 1'b1};
            prev_s <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            prev_s <= chain[LAST];
        end
    end

    assign now_s = chain[LAST];

endmodule

// File: rtl/hs_cond_det.sv
module hs_cond_det
    import hs_trk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  bus_t now_s,
    input  bus_t prev_s,
    output logic start_q,
    output logic stop_q,
    output logic scl_rise
);
    logic scl_held;

    assign scl_held = now_s.scl & prev_s.scl;
    assign scl_rise = now_s.scl & ~prev_s.scl;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            start_q <= scl_held & prev_s.sda & ~now_s.sda;
            stop_q  <= scl_held & ~prev_s.sda & now_s.sda;
        end
    end

endmodule

// File: rtl/hs_byte_rx.sv
module hs_byte_rx
    import hs_trk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_q,
    input  logic    stop_q,
    input  logic    scl_rise,
    input  logic    sda,
    output rx_evt_t evt
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
            evt     <= '0;
        end else begin
            evt.done     <= 1'b0;
            evt.ack_done <= 1'b0;
            if (start_q || stop_q) begin
                bit_cnt <= '0;
            end else if (scl_rise) begin
                if (bit_cnt == ACK_SLOT) begin
                    evt.ack_done <= 1'b1;
                    evt.ack_bit  <= sda;
                    bit_cnt      <= '0;
                end else begin
                    shreg   <= {shreg[BYTE_W-2:0], sda};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == ACK_SLOT - 1'b1) begin
                        evt.done <= 1'b1;
                        evt.data <= {shreg[BYTE_W-2:0], sda};
                    end
                end
            end
        end
    end

    AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= ACK_SLOT); // R5
    AST_BYTE_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(evt.done && evt.ack_done)); // R5

endmodule

// File: rtl/i2c_hs_tracker.sv
module i2c_hs_tracker
    import hs_trk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  hs_mode,
    output logic                  code_det,
    output logic [CODE_IDX_W-1:0] code_idx,
    output logic                  start_det,
    output logic                  stop_det,
    output logic                  addr_valid,
    output logic [ADDR_W-1:0]     addr,
    output logic                  addr_rw,
    output logic                  nack_err
);
    bus_t    now_s, prev_s;
    logic    start_q, stop_q, scl_rise;
    rx_evt_t rx;
    phase_t  phase;

    hs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ('{scl: scl_i, sda: sda_i}),
        .now_s  (now_s),
        .prev_s (prev_s)
    );

    hs_cond_det u_cond (
        .clk      (clk),
        .rst      (rst),
        .now_s    (now_s),
        .prev_s   (prev_s),
        .start_q  (start_q),
        .stop_q   (stop_q),
        .scl_rise (scl_rise)
    );

    hs_byte_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .start_q  (start_q),
        .stop_q   (stop_q),
        .scl_rise (scl_rise),
        .sda      (now_s.sda),
        .evt      (rx)
    );

    assign start_det = start_q;
    assign stop_det  = stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            hs_mode    <= 1'b0;
            code_det   <= 1'b0;
            code_idx   <= '0;
            addr_valid <= 1'b0;
            addr       <= '0;
            addr_rw    <= 1'b0;
            nack_err   <= 1'b0;
        end else begin
            code_det   <= 1'b0;
            addr_valid <= 1'b0;
            nack_err   <= 1'b0;
            if (stop_q) begin
                hs_mode <= 1'b0;
                phase   <= PH_IDLE;
            end else if (start_q) begin
                phase   <= PH_FIRST;
                addr    <= '0;
                addr_rw <= 1'b0;
            end else if (rx.done && phase == PH_FIRST) begin
                if (!hs_mode && is_hs_code(rx.data)) begin
                    hs_mode  <= 1'b1;
                    code_det <= 1'b1;
                    code_idx <= rx.data[CODE_IDX_W-1:0];
                    phase    <= PH_CODE_ACK;
                end else begin
                    addr_valid <= 1'b1;
                    addr       <= rx.data[BYTE_W-1:1];
                    addr_rw    <= rx.data[0];
                    phase      <= PH_PAYLOAD;
                end
            end else if (rx.ack_done && phase == PH_CODE_ACK) begin
                nack_err <= ~rx.ack_bit;
                phase    <= PH_WAIT_RS;
            end
        end
    end

    AST_STOP_CLEARS_HS: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !hs_mode); // R7
    AST_RS_HOLDS_HS: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && start_det && !stop_det) |=> hs_mode); // R6
    AST_HS_NEEDS_CODE: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode) |-> code_det); // R4
    AST_ONE_BYTE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({code_det, addr_valid, nack_err})); // R9
    AST_NACK_IN_HS: assert property (@(posedge clk) disable iff (rst)
        nack_err |-> hs_mode); // R8

endmodule

// File: tb/sim_i2c_hs_tracker.sv
`timescale 1ns/1ps
module sim_i2c_hs_tracker;
    localparam int H = 8;
    localparam int NVEC = 6;
    // {first byte, ninth bit after it, address byte used after repeated START}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h08, 1'b1, 8'hA4},
        {8'h0F, 1'b1, 8'h91},
        {8'h0D, 1'b0, 8'h3E},
        {8'h90, 1'b0, 8'h00},
        {8'h07, 1'b0, 8'h00},
        {8'h10, 1'b0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_r = 1'b1, sda_r = 1'b1;
    logic hs_mode, code_det, start_det, stop_det, addr_valid, addr_rw, nack_err;
    logic [2:0] code_idx;
    logic [6:0] addr;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rise_cyc = 0;
    int c_start = 0, c_stop = 0, c_code = 0, c_addr = 0, c_nack = 0;
    int last_start_cyc = 0, last_code_cyc = 0;

    always #2 clk = ~clk;

    i2c_hs_tracker u0 (
        .clk(clk), .rst(rst), .scl_i(scl_r), .sda_i(sda_r),
        .hs_mode(hs_mode), .code_det(code_det), .code_idx(code_idx),
        .start_det(start_det), .stop_det(stop_det), .addr_valid(addr_valid),
        .addr(addr), .addr_rw(addr_rw), .nack_err(nack_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (start_det) begin c_start++; last_start_cyc = cyc; end
            if (stop_det) c_stop++;
            if (code_det) begin c_code++; last_code_cyc = cyc; end
            if (addr_valid) c_addr++;
            if (nack_err) c_nack++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_start();
        scl_r = 1'b1; sda_r = 1'b1; wclk(H);
        sda_r = 1'b0; wclk(H);
        scl_r = 1'b0; wclk(H);
    endtask

    task automatic send_rstart();
        sda_r = 1'b1; wclk(H);
        scl_r = 1'b1; wclk(H);
        sda_r = 1'b0; wclk(H);
        scl_r = 1'b0; wclk(H);
    endtask

    task automatic send_stop();
        sda_r = 1'b0; wclk(H);
        scl_r = 1'b1; wclk(H);
        sda_r = 1'b1; wclk(H);
    endtask

    task automatic send_bit(input logic b);
        sda_r = b; wclk(H);
        scl_r = 1'b1; rise_cyc = cyc; wclk(H);
        scl_r = 1'b0; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s0, k_code, k_addr, k_nack, k_stop;
        logic [7:0] b1, b2;
        logic ackb, iscode;
        wclk(5);
        chk(hs_mode == 0 && code_det == 0 && addr_valid == 0 && nack_err == 0, "R1", "flags in reset",
            {hs_mode, code_det, addr_valid, nack_err}, 0);
        chk(code_idx == 0 && addr == 0 && addr_rw == 0, "R1", "values in reset", {code_idx, addr, addr_rw}, 0);
        rst = 1'b0;
        wclk(5);
        chk(c_start == 0 && c_stop == 0 && start_det == 0, "R1", "no events after reset", c_start + c_stop, 0);

        // Directed: exact latencies, then reset while in high-speed mode
        wclk(H);
        s0 = cyc;
        sda_r = 1'b0; wclk(H);
        chk(last_start_cyc - s0 == 3, "R2", "start latency", last_start_cyc - s0, 3);
        chk(c_start == 1, "R2", "start pulse count", c_start, 1);
        scl_r = 1'b0; wclk(H);
        send_byte(8'h0A);
        chk(last_code_cyc - rise_cyc == 4, "R4", "code latency", last_code_cyc - rise_cyc, 4);
        chk(hs_mode == 1 && code_idx == 2, "R4", "hs after 0x0A", {hs_mode, code_idx}, 4'b1010);
        send_bit(1'b1);
        rst = 1'b1; wclk(2); rst = 1'b0; wclk(2);
        chk(hs_mode == 0, "R1", "reset drops hs", hs_mode, 0);
        send_stop();
        wclk(H);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            {b1, ackb, b2} = VEC[v];
            iscode = (b1[7:3] == 5'b00001);
            k_code = c_code; k_addr = c_addr; k_nack = c_nack; k_stop = c_stop;
            send_start();
            chk(hs_mode == 0, "R4", "starts in std mode", hs_mode, 0);
            send_byte(b1);
            send_bit(ackb);
            chk(hs_mode == iscode, "R4", "hs after first byte", hs_mode, iscode);
            chk(c_code - k_code == int'(iscode), "R4", "code pulses", c_code - k_code, iscode);
            chk(c_nack - k_nack == int'(iscode && !ackb), "R8", "nack pulses", c_nack - k_nack, iscode && !ackb);
            if (iscode) begin
                chk(code_idx == b1[2:0], "R4", "code index", code_idx, b1[2:0]);
                chk(c_addr == k_addr, "R4", "code is not address", c_addr - k_addr, 0);
                send_rstart();
                chk(hs_mode == 1, "R6", "hs held over repeated start", hs_mode, 1);
                send_byte(b2);
                send_bit(1'b0);
                chk(c_addr - k_addr == 1, "R6", "address pulse", c_addr - k_addr, 1);
                chk(addr == b2[7:1] && addr_rw == b2[0], "R6", "address value", {addr, addr_rw}, b2);
            end else begin
                chk(c_addr - k_addr == 1, "R5", "address pulse", c_addr - k_addr, 1);
                chk(addr == b1[7:1] && addr_rw == b1[0], "R5", "address value", {addr, addr_rw}, b1);
            end
            k_code = c_code; k_addr = c_addr;
            send_byte(8'h0B);
            send_bit(1'b0);
            chk(c_code == k_code && c_addr == k_addr, "R9", "data byte in code range ignored",
                (c_code - k_code) + (c_addr - k_addr), 0);
            chk(hs_mode == iscode, "R9", "hs unchanged by data", hs_mode, iscode);
            send_stop();
            chk(c_stop - k_stop == 1, "R3", "stop pulse", c_stop - k_stop, 1);
            chk(hs_mode == 0, "R7", "stop clears hs", hs_mode, 0);
            wclk(H);
        end

        // Address held after STOP, cleared by next START
        chk(addr == 7'h08 && addr_rw == 0, "R10", "address held after stop", {addr, addr_rw}, 8'h10);
        send_start();
        chk(addr == 0 && addr_rw == 0, "R10", "start clears address", {addr, addr_rw}, 0);
        k_code = c_code;
        send_stop();
        chk(c_code == k_code && hs_mode == 0, "R3", "start+stop with no data", c_code - k_code, 0);
        wclk(H);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule